// File: doc/BRIEF.md
# Run-Length Column Packer

This block compresses one column of a state-transition table for memory storage. The column arrives as a stream of next-state values in row order, one value per beat. A start-of-column marker and an end-of-column marker frame each column. The block turns each run of equal values into one pair. The pair holds the value and the row where that run begins.

The pairs are packed into fixed-width groups, and each group is written to a group memory as one word. When a column ends, the block writes one index record. For each group of the column, the record gives the group's memory address and the first row that the group covers. A lookup engine can then find the group for a given row by comparing against the record, and find the value by comparing against the positions inside that group.

Groups take consecutive addresses across all columns. Index records are addressed by column number.

Top module: `rlc_column_packer`

## Requirements
- R1: Each pair holds a value and the row where its run starts. A new pair starts at row 0 of every column, even when that value equals the last value of the previous column. A new pair also starts at any row whose value differs from the row before it.
- R2: Within a column, two consecutive pairs never carry the same value. A run of equal rows gives exactly one pair.
- R3: A pair is packed as {value, position}, with the position in the low POS_W bits. Slot j of a group word sits at bits [j*PAIR_W +: PAIR_W]. A group is written as soon as GROUP_L pairs have collected.
- R4: The last group of a column is written when the column ends, even if it is partly filled. Its empty slots hold value 0 and position 2^POS_W-1, where POS_W = clog2(NUM_STATES+1). This position is larger than any valid row.
- R5: Group addresses start at 0 after reset and rise by one for every group written. They run across column boundaries.
- R6: One index record is written per column. Its address is the column number, counted from 0 after reset. Entry j sits at bits [j*ENT_W +: ENT_W] and holds {group address, first position of that group}, with the position in the low bits. Unused entries hold {0, 2^POS_W-1}.
- R7: A column may need more than MAX_GROUPS groups. In that case the overflow output is high together with that column's index write. The record keeps only the first MAX_GROUPS entries, but every group is still written. In all other cycles the overflow output is low.
- R8: After reset, and before any input, there is no group write, no index write and no overflow.
- R9: A column whose pair count is a multiple of GROUP_L produces exactly (pair count / GROUP_L) groups. No group made only of padding is written.
- R10: All group writes of a column come before that column's index write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input beat valid |
| in_sof_i | input | 1 | Beat is row 0 of a column |
| in_eof_i | input | 1 | Beat is the last row of a column |
| in_state_i | input | VAL_W | Next-state value of this row |
| grp_we_o | output | 1 | Group memory write strobe |
| grp_addr_o | output | GADDR_W | Group memory address |
| grp_data_o | output | GROUP_L*PAIR_W | Packed group word |
| idx_we_o | output | 1 | Index record write strobe |
| idx_addr_o | output | COL_W | Index record address (column number) |
| idx_data_o | output | MAX_GROUPS*ENT_W | Packed index record |
| ovf_o | output | 1 | Column needed more groups than the record holds |

## Verification
The bench builds the block with NUM_STATES=16, GROUP_L=4 and MAX_GROUPS=3. With these values, a column of sixteen distinct rows needs four groups, which is one more than the record holds. Twelve distinct rows fill the record exactly, and eight distinct rows end on a full group. The short columns make partly filled groups and the padding sentinel common. The random columns have random lengths and random gaps between beats, and they carry runs that cross group boundaries.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  typedef struct packed {
    logic beat;
    logic fresh;
    logic last;
  } rlc_tag_t;

  function automatic int unsigned rlc_pos_w(int unsigned n);
    return $clog2(n + 1);
  endfunction

  function automatic int unsigned rlc_val_w(int unsigned n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rlc_run_detect.sv
module rlc_run_detect #(
  parameter int VAL_W = 4,
  parameter int POS_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic                in_sof_i,
  input  logic                in_eof_i,
  input  logic [VAL_W-1:0]    in_state_i,
  output rlc_pkg::rlc_tag_t   tag_o,
  output logic [VAL_W-1:0]    val_o,
  output logic [POS_W-1:0]    pos_o
);
  logic [VAL_W-1:0] prev_q;
  logic [POS_W-1:0] row_q;
  logic [POS_W-1:0] cur_pos;
  logic             fresh;

  // row 0 always opens a run, whatever the previous column ended with
  assign cur_pos = in_sof_i ? '0 : row_q;
  assign fresh   = in_sof_i || (in_state_i != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      row_q  <= '0;
      tag_o  <= '0;
      val_o  <= '0;
      pos_o  <= '0;
    end else begin
      tag_o.beat  <= in_valid_i;
      tag_o.fresh <= in_valid_i && fresh;
      tag_o.last  <= in_valid_i && in_eof_i;
      if (in_valid_i) begin
        prev_q <= in_state_i;
        row_q  <= cur_pos + POS_W'(1);
        val_o  <= in_state_i;
        pos_o  <= cur_pos;
      end
    end
  end
endmodule

// File: rtl/rlc_group_pack.sv
module rlc_group_pack #(
  parameter int VAL_W   = 4,
  parameter int POS_W   = 5,
  parameter int GROUP_L = 4,
  parameter int GADDR_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  rlc_pkg::rlc_tag_t              tag_i,
  input  logic [VAL_W-1:0]               val_i,
  input  logic [POS_W-1:0]               pos_i,
  output logic                           grp_we_o,
  output logic [GADDR_W-1:0]             grp_addr_o,
  output logic [GROUP_L*(VAL_W+POS_W)-1:0] grp_data_o,
  output logic [POS_W-1:0]               first_pos_o,
  output logic                           col_end_o
);
  localparam int PAIR_W = VAL_W + POS_W;
  localparam int CNT_W  = (GROUP_L > 1) ? $clog2(GROUP_L) : 1;
  localparam logic [PAIR_W-1:0] PAD_PAIR = {{VAL_W{1'b0}}, {POS_W{1'b1}}};

  logic [PAIR_W-1:0] slot_q [GROUP_L];
  logic [PAIR_W-1:0] slot_n [GROUP_L];
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W:0]    fill;
  logic [POS_W-1:0]  head_q, head_n;
  logic [GADDR_W-1:0] gaddr_q;
  logic [GROUP_L*PAIR_W-1:0] word;
  logic full, flush, emit;

  assign fill   = {1'b0, cnt_q} + (CNT_W+1)'(tag_i.fresh);
  assign full   = tag_i.fresh && (cnt_q == CNT_W'(GROUP_L-1));
  // an empty buffer at column end means the last group already went out full
  assign flush  = tag_i.last && ((cnt_q != '0) || tag_i.fresh);
  assign emit   = full || flush;
  assign head_n = (tag_i.fresh && cnt_q == '0) ? pos_i : head_q;

  always_comb begin
    for (int j = 0; j < GROUP_L; j++) begin
      slot_n[j] = (tag_i.fresh && cnt_q == CNT_W'(j)) ? {val_i, pos_i} : slot_q[j];
      word[j*PAIR_W +: PAIR_W] = ((CNT_W+1)'(j) < fill) ? slot_n[j] : PAD_PAIR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < GROUP_L; j++) slot_q[j] <= '0;
      cnt_q       <= '0;
      head_q      <= '0;
      gaddr_q     <= '0;
      grp_we_o    <= 1'b0;
      grp_addr_o  <= '0;
      grp_data_o  <= '0;
      first_pos_o <= '0;
      col_end_o   <= 1'b0;
    end else begin
      for (int j = 0; j < GROUP_L; j++) slot_q[j] <= slot_n[j];
      head_q    <= head_n;
      grp_we_o  <= emit;
      col_end_o <= tag_i.last;
      if (emit) begin
        cnt_q       <= '0;
        grp_addr_o  <= gaddr_q;
        grp_data_o  <= word;
        first_pos_o <= head_n;
        gaddr_q     <= gaddr_q + GADDR_W'(1);
      end else if (tag_i.fresh) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rlc_index_build.sv
module rlc_index_build #(
  parameter int POS_W      = 5,
  parameter int GADDR_W    = 8,
  parameter int MAX_GROUPS = 4,
  parameter int COL_W      = 4
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  g_we_i,
  input  logic [GADDR_W-1:0]                    g_addr_i,
  input  logic [POS_W-1:0]                      g_pos_i,
  input  logic                                  col_end_i,
  output logic                                  idx_we_o,
  output logic [COL_W-1:0]                      idx_addr_o,
  output logic [MAX_GROUPS*(GADDR_W+POS_W)-1:0] idx_data_o,
  output logic                                  ovf_o
);
  localparam int ENT_W = GADDR_W + POS_W;
  localparam int NUM_W = $clog2(MAX_GROUPS + 1);
  localparam logic [ENT_W-1:0] EMPTY_ENT = {{GADDR_W{1'b0}}, {POS_W{1'b1}}};

  logic [ENT_W-1:0] ent_q [MAX_GROUPS];
  logic [ENT_W-1:0] ent_n [MAX_GROUPS];
  logic [NUM_W-1:0] num_q, num_n;
  logic             ovf_q, ovf_n;
  logic [COL_W-1:0] col_q;
  logic [MAX_GROUPS*ENT_W-1:0] rec;

  always_comb begin
    num_n = num_q;
    ovf_n = ovf_q;
    if (g_we_i) begin
      if (num_q < NUM_W'(MAX_GROUPS)) num_n = num_q + NUM_W'(1);
      else                            ovf_n = 1'b1;
    end
    for (int j = 0; j < MAX_GROUPS; j++) begin
      ent_n[j] = (g_we_i && num_q == NUM_W'(j)) ? {g_addr_i, g_pos_i} : ent_q[j];
      rec[j*ENT_W +: ENT_W] = ent_n[j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < MAX_GROUPS; j++) ent_q[j] <= EMPTY_ENT;
      num_q      <= '0;
      ovf_q      <= 1'b0;
      col_q      <= '0;
      idx_we_o   <= 1'b0;
      idx_addr_o <= '0;
      idx_data_o <= '0;
      ovf_o      <= 1'b0;
    end else begin
      idx_we_o <= col_end_i;
      ovf_o    <= col_end_i && ovf_n;
      if (col_end_i) begin
        idx_data_o <= rec;
        idx_addr_o <= col_q;
        col_q      <= col_q + COL_W'(1);
        for (int j = 0; j < MAX_GROUPS; j++) ent_q[j] <= EMPTY_ENT;
        num_q <= '0;
        ovf_q <= 1'b0;
      end else begin
        for (int j = 0; j < MAX_GROUPS; j++) ent_q[j] <= ent_n[j];
        num_q <= num_n;
        ovf_q <= ovf_n;
      end
    end
  end
endmodule

// File: rtl/rlc_column_packer.sv
module rlc_column_packer #(
  parameter int NUM_STATES = 256,
  parameter int GROUP_L    = 4,
  parameter int MAX_GROUPS = 8,
  parameter int GADDR_W    = 12,
  parameter int COL_W      = 8,
  localparam int VAL_W     = rlc_pkg::rlc_val_w(NUM_STATES),
  localparam int POS_W     = rlc_pkg::rlc_pos_w(NUM_STATES),
  localparam int PAIR_W    = VAL_W + POS_W,
  localparam int ENT_W     = GADDR_W + POS_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  input  logic                          in_sof_i,
  input  logic                          in_eof_i,
  input  logic [VAL_W-1:0]              in_state_i,
  output logic                          grp_we_o,
  output logic [GADDR_W-1:0]            grp_addr_o,
  output logic [GROUP_L*PAIR_W-1:0]     grp_data_o,
  output logic                          idx_we_o,
  output logic [COL_W-1:0]              idx_addr_o,
  output logic [MAX_GROUPS*ENT_W-1:0]   idx_data_o,
  output logic                          ovf_o
);
  rlc_pkg::rlc_tag_t  tag;
  logic [VAL_W-1:0]   run_val;
  logic [POS_W-1:0]   run_pos;
  logic [POS_W-1:0]   grp_first_pos;
  logic               col_end;

  rlc_run_detect #(.VAL_W(VAL_W), .POS_W(POS_W)) u_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_sof_i   (in_sof_i),
    .in_eof_i   (in_eof_i),
    .in_state_i (in_state_i),
    .tag_o      (tag),
    .val_o      (run_val),
    .pos_o      (run_pos)
  );

  rlc_group_pack #(
    .VAL_W(VAL_W), .POS_W(POS_W), .GROUP_L(GROUP_L), .GADDR_W(GADDR_W)
  ) u_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tag_i       (tag),
    .val_i       (run_val),
    .pos_i       (run_pos),
    .grp_we_o    (grp_we_o),
    .grp_addr_o  (grp_addr_o),
    .grp_data_o  (grp_data_o),
    .first_pos_o (grp_first_pos),
    .col_end_o   (col_end)
  );

  rlc_index_build #(
    .POS_W(POS_W), .GADDR_W(GADDR_W), .MAX_GROUPS(MAX_GROUPS), .COL_W(COL_W)
  ) u_index (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .g_we_i     (grp_we_o),
    .g_addr_i   (grp_addr_o),
    .g_pos_i    (grp_first_pos),
    .col_end_i  (col_end),
    .idx_we_o   (idx_we_o),
    .idx_addr_o (idx_addr_o),
    .idx_data_o (idx_data_o),
    .ovf_o      (ovf_o)
  );
endmodule

// File: rtl/rlc_column_packer_chk.sv
module rlc_column_packer_chk #(
  parameter int NUM_STATES = 256,
  parameter int GROUP_L    = 4,
  parameter int MAX_GROUPS = 8,
  parameter int GADDR_W    = 12,
  parameter int COL_W      = 8,
  localparam int VAL_W     = rlc_pkg::rlc_val_w(NUM_STATES),
  localparam int POS_W     = rlc_pkg::rlc_pos_w(NUM_STATES),
  localparam int PAIR_W    = VAL_W + POS_W,
  localparam int ENT_W     = GADDR_W + POS_W
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        grp_we_o,
  input logic [GADDR_W-1:0]          grp_addr_o,
  input logic [GROUP_L*PAIR_W-1:0]   grp_data_o,
  input logic                        idx_we_o,
  input logic [COL_W-1:0]            idx_addr_o,
  input logic [MAX_GROUPS*ENT_W-1:0] idx_data_o,
  input logic                        ovf_o
);
  localparam logic [POS_W-1:0] PAD_POS = {POS_W{1'b1}};

  logic               seen_g, seen_c;
  logic [GADDR_W-1:0] last_ga;
  logic [COL_W-1:0]   last_col;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_g   <= 1'b0;
      seen_c   <= 1'b0;
      last_ga  <= '0;
      last_col <= '0;
    end else begin
      if (grp_we_o) begin seen_g <= 1'b1; last_ga <= grp_addr_o; end
      if (idx_we_o) begin seen_c <= 1'b1; last_col <= idx_addr_o; end
    end
  end

  assert_first_gaddr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_we_o && !seen_g) |-> grp_addr_o == '0);
  assert_gaddr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_we_o && seen_g) |-> grp_addr_o == last_ga + GADDR_W'(1));
  assert_first_col_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_we_o && !seen_c) |-> idx_addr_o == '0);
  assert_col_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_we_o && seen_c) |-> idx_addr_o == last_col + COL_W'(1));
  assert_ovf_qual_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> idx_we_o);
  assert_slot0_used_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_we_o |-> grp_data_o[0 +: POS_W] != PAD_POS);

  for (genvar j = 0; j < GROUP_L - 1; j++) begin : g_slot
    logic [POS_W-1:0] pa, pb;
    logic [VAL_W-1:0] va, vb;
    assign pa = grp_data_o[j*PAIR_W +: POS_W];
    assign pb = grp_data_o[(j+1)*PAIR_W +: POS_W];
    assign va = grp_data_o[j*PAIR_W + POS_W +: VAL_W];
    assign vb = grp_data_o[(j+1)*PAIR_W + POS_W +: VAL_W];

    assert_pad_tail_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grp_we_o && pa == PAD_POS) |-> pb == PAD_POS);
    assert_run_break_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grp_we_o && pb != PAD_POS) |-> va != vb);
    assert_pos_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grp_we_o && pb != PAD_POS) |-> pa < pb);
  end
endmodule

bind rlc_column_packer rlc_column_packer_chk #(
  .NUM_STATES(NUM_STATES), .GROUP_L(GROUP_L), .MAX_GROUPS(MAX_GROUPS),
  .GADDR_W(GADDR_W), .COL_W(COL_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .grp_we_o   (grp_we_o),
  .grp_addr_o (grp_addr_o),
  .grp_data_o (grp_data_o),
  .idx_we_o   (idx_we_o),
  .idx_addr_o (idx_addr_o),
  .idx_data_o (idx_data_o),
  .ovf_o      (ovf_o)
);

// File: tb/sim_rlc_column_packer.sv
module sim_rlc_column_packer;
  localparam int CLK_P = 10;
  localparam int NS    = 16;
  localparam int GL    = 4;
  localparam int MG    = 3;
  localparam int GAW   = 8;
  localparam int CW    = 4;
  localparam int VW    = 4;
  localparam int PW    = 5;
  localparam int PAIRW = VW + PW;
  localparam int GW    = GL * PAIRW;
  localparam int EW    = GAW + PW;
  localparam int RW    = MG * EW;
  localparam logic [PW-1:0] PAD = 5'd31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [VW-1:0] in_state = '0;
  logic grp_we, idx_we, ovf;
  logic [GAW-1:0] grp_addr;
  logic [GW-1:0] grp_data;
  logic [CW-1:0] idx_addr;
  logic [RW-1:0] idx_data;

  always #(CLK_P/2) clk = ~clk;

  rlc_column_packer #(
    .NUM_STATES(NS), .GROUP_L(GL), .MAX_GROUPS(MG), .GADDR_W(GAW), .COL_W(CW)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_sof_i(in_sof),
    .in_eof_i(in_eof), .in_state_i(in_state), .grp_we_o(grp_we),
    .grp_addr_o(grp_addr), .grp_data_o(grp_data), .idx_we_o(idx_we),
    .idx_addr_o(idx_addr), .idx_data_o(idx_data), .ovf_o(ovf)
  );

  int errors = 0, checks = 0;
  int ng_act = 0;
  bit idx_seen = 0;
  bit grp_after_idx = 0;
  bit done = 0;
  logic [GW-1:0]  g_data [8];
  logic [GAW-1:0] g_addr [8];
  logic [RW-1:0]  r_data;
  logic [CW-1:0]  r_addr;
  logic           r_ovf;
  int col_vals [16];
  int exp_gaddr = 0;
  int col_no = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (grp_we) begin
        if (ng_act < 8) begin
          g_data[ng_act] = grp_data;
          g_addr[ng_act] = grp_addr;
        end
        if (idx_seen) grp_after_idx = 1;
        ng_act++;
      end
      if (idx_we) begin
        r_data = idx_data; r_addr = idx_addr; r_ovf = ovf; idx_seen = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_col(input int n, input int idle_max);
    int pv [16];
    int pp [16];
    int np, ngx, wt;
    logic [GW-1:0] ed;
    logic [RW-1:0] er;
    ng_act = 0; idx_seen = 0; grp_after_idx = 0;
    for (int r = 0; r < n; r++) begin
      @(posedge clk); #1;
      in_valid = 1; in_sof = (r == 0); in_eof = (r == n - 1);
      in_state = VW'(col_vals[r]);
      if (idle_max > 0) begin
        for (int k = 0; k < int'($urandom % (idle_max + 1)); k++) begin
          @(posedge clk); #1; in_valid = 0; in_sof = 0; in_eof = 0;
        end
      end
    end
    @(posedge clk); #1; in_valid = 0; in_sof = 0; in_eof = 0;
    wt = 0;
    while (!idx_seen && wt < 20) begin @(posedge clk); wt++; end
    repeat (3) @(posedge clk);
    // expected pairs: R1 new run at row 0 or on value change
    np = 0;
    for (int r = 0; r < n; r++) begin
      if (r == 0 || col_vals[r] != col_vals[r-1]) begin
        pv[np] = col_vals[r]; pp[np] = r; np++;
      end
    end
    ngx = (np + GL - 1) / GL;
    chk(idx_seen, "R6 index write seen", 64'(idx_seen), 64'd1);
    chk(ng_act == ngx, (np % GL == 0) ? "R9 group count" : "R3 group count",
        64'(ng_act), 64'(ngx));
    chk(!grp_after_idx, "R10 groups before index", 64'(grp_after_idx), 64'd0);
    for (int g = 0; g < ngx && g < 8 && g < ng_act; g++) begin
      for (int s = 0; s < GL; s++) begin
        int i;
        i = g * GL + s;
        ed[s*PAIRW +: PAIRW] = (i < np) ? {VW'(pv[i]), PW'(pp[i])} : {{VW{1'b0}}, PAD};
      end
      chk(g_data[g] == ed, "R1 R2 R3 R4 group data", 64'(g_data[g]), 64'(ed));
      chk(g_addr[g] == GAW'(exp_gaddr + g), "R5 group address", 64'(g_addr[g]),
          64'(GAW'(exp_gaddr + g)));
    end
    for (int e = 0; e < MG; e++)
      er[e*EW +: EW] = (e < ngx) ? {GAW'(exp_gaddr + e), PW'(pp[e*GL])} : {{GAW{1'b0}}, PAD};
    chk(r_data == er, "R6 index record", 64'(r_data), 64'(er));
    chk(r_addr == CW'(col_no), "R6 index address", 64'(r_addr), 64'(CW'(col_no)));
    chk(r_ovf == (ngx > MG), "R7 overflow flag", 64'(r_ovf), 64'(ngx > MG));
    exp_gaddr += ngx;
    col_no++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired (all requirements)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cur, n;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #2;
    chk(grp_we == 0, "R8 no group write after reset", 64'(grp_we), 64'd0);
    chk(idx_we == 0, "R8 no index write after reset", 64'(idx_we), 64'd0);
    chk(ovf == 0, "R8 no overflow after reset", 64'(ovf), 64'd0);

    // R2: one long run -> one pair, padded group (R4)
    for (int r = 0; r < 16; r++) col_vals[r] = 7;
    run_col(16, 0);
    // R1: next column starts with same value, still new pair at row 0
    for (int r = 0; r < 5; r++) col_vals[r] = 7;
    run_col(5, 1);
    // R7: 16 distinct rows -> 4 groups, record holds 3
    for (int r = 0; r < 16; r++) col_vals[r] = r;
    run_col(16, 0);
    // R9: 8 pairs end exactly on a group boundary
    for (int r = 0; r < 8; r++) col_vals[r] = 15 - r;
    run_col(8, 2);
    // single-row column
    col_vals[0] = 3;
    run_col(1, 0);
    // alternating: 12 pairs fill the record exactly, no overflow
    for (int r = 0; r < 12; r++) col_vals[r] = r % 2;
    run_col(12, 0);
    // random run-structured columns
    for (int c = 0; c < 24; c++) begin
      n = 1 + int'($urandom % 16);
      cur = int'($urandom % 16);
      for (int r = 0; r < n; r++) begin
        if ($urandom % 3 == 0) cur = int'($urandom % 16);
        col_vals[r] = cur;
      end
      run_col(n, (c % 3 == 0) ? 0 : 2);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule